// File: doc/BRIEF.md
# Relative Branch Target Unit

This block resolves the program counter that follows a PC-relative branch. Each cycle in which `in_valid` is high it takes the address of the first opcode byte, up to four instruction bytes, and the zero flag. It classifies the instruction as a short branch (single opcode byte plus an 8-bit signed displacement) or a long branch (prefix byte `18`, opcode byte, then a 16-bit displacement with the high byte first). It then decides whether the branch is taken and registers the resulting address one cycle later.

The displacement counts from the address just past the complete instruction. For a short form that address is PC+2, and for a long form it is PC+4. A branch that is not taken falls through to that same address. Three conditions are decoded: always, zero flag set, and zero flag clear. Any other byte pattern is reported as not a branch, and its address is passed through unchanged.

Top module: `rbt_unit`

## Requirements
- R1: While `rst_n` is low, and until the first accepted input, `out_valid`, `taken` and `is_branch` are 0 and `next_pc` is 0.
- R2: `out_valid` equals the value `in_valid` had at the previous rising clock edge, so each result appears exactly one cycle after its input.
- R3: Opcode byte 0x20 in `ins_b0` is a short unconditional branch. It is always taken, and `next_pc` = PC + 2 + sign-extended `ins_b1`. For example, PC 0x0800 with offset 0x35 gives 0x0837, and PC 0x0800 with offset 0xC7 gives 0x07C9.
- R4: Opcode byte 0x27 in `ins_b0` is a short branch on zero flag set. It is taken when `flag_z`=1 and goes to PC + 2 + sign-extended offset. Otherwise `next_pc` = PC + 2 and `taken` = 0.
- R5: Opcode byte 0x26 in `ins_b0` is a short branch on zero flag clear. It is taken when `flag_z`=0 and goes to the same target formula as R4. Otherwise it falls through to PC + 2.
- R6: When `ins_b0` = 0x18, `ins_b1` selects a long form: 0x20 is always taken, 0x27 is taken on zero flag set, and 0x26 is taken on zero flag clear. The offset is {`ins_b2`,`ins_b3`}. The target is PC + 4 + offset and the fall-through is PC + 4. For example, PC 0x1000 with offset 0x021A and Z=1 gives 0x121E, and with Z=0 gives 0x1004.
- R7: All address arithmetic wraps modulo 2^16. For example, a short branch at PC 0xFFFE with offset 0x05 goes to 0x0005.
- R8: Any other byte pattern, including 0x18 followed by an undecoded byte, gives `is_branch`=0, `taken`=0 and `next_pc` = the input PC. `is_branch`=1 for every decoded form.
- R9: While `in_valid` is low, `next_pc`, `taken` and `is_branch` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction bytes and PC are presented this cycle |
| pc_in | input | 16 | Address of the first instruction byte |
| ins_b0 | input | 8 | First instruction byte (opcode or long prefix) |
| ins_b1 | input | 8 | Second byte (short offset or long opcode) |
| ins_b2 | input | 8 | Third byte (long offset high) |
| ins_b3 | input | 8 | Fourth byte (long offset low) |
| flag_z | input | 1 | Zero flag from the condition codes |
| out_valid | output | 1 | Registered result is fresh |
| next_pc | output | 16 | Resolved next program counter |
| taken | output | 1 | Branch was taken |
| is_branch | output | 1 | Input decoded as a supported branch |

## Verification
The bench instantiates the unit with its default 16-bit PC width. With that width, wrap-around at both ends of the address space can be reached with short offsets near the 0xFFFF boundary and with long offsets. The width of the long displacement equals the PC width, so both backward and forward long jumps cover the whole space. The directed cases cover the worked offsets and the boundary PCs. A random stream then mixes all six branch forms, undecoded opcodes and idle cycles against the behavioural model.

// File: rtl/rbt_pkg.sv
package rbt_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OPC_LONG_PREFIX = 8'h18;
    localparam logic [BYTE_W-1:0] OPC_ALWAYS      = 8'h20;
    localparam logic [BYTE_W-1:0] OPC_IF_NE       = 8'h26;
    localparam logic [BYTE_W-1:0] OPC_IF_EQ       = 8'h27;

    typedef enum logic [1:0] {
        BK_NONE,
        BK_ALWAYS,
        BK_IF_EQ,
        BK_IF_NE
    } br_kind_e;
endpackage

// File: rtl/rbt_decode.sv
module rbt_decode
    import rbt_pkg::*;
(
    input  logic [BYTE_W-1:0] b0,
    input  logic [BYTE_W-1:0] b1,
    output br_kind_e          kind,
    output logic              is_long
);
    logic [BYTE_W-1:0] opc;

    always_comb begin
        is_long = (b0 == OPC_LONG_PREFIX);
        opc     = is_long ? b1 : b0;
        case (opc)
            OPC_ALWAYS: kind = BK_ALWAYS;
            OPC_IF_EQ:  kind = BK_IF_EQ;
            OPC_IF_NE:  kind = BK_IF_NE;
            default:    kind = BK_NONE;
        endcase
    end
endmodule

// File: rtl/rbt_cond.sv
module rbt_cond
    import rbt_pkg::*;
(
    input  br_kind_e kind,
    input  logic     zero,
    output logic     take
);
    always_comb begin
        case (kind)
            BK_ALWAYS: take = 1'b1;
            BK_IF_EQ:  take = zero;
            BK_IF_NE:  take = ~zero;
            default:   take = 1'b0;
        endcase
    end
endmodule

// File: rtl/rbt_addr.sv
module rbt_addr #(
    parameter int PC_W    = 16,
    parameter int SHORT_W = 8,
    parameter int LONG_W  = 16
) (
    input  logic [PC_W-1:0]    pc,
    input  logic               is_long,
    input  logic [SHORT_W-1:0] short_off,
    input  logic [LONG_W-1:0]  long_off,
    output logic [PC_W-1:0]    fall_pc,
    output logic [PC_W-1:0]    tgt_pc
);
    localparam logic [PC_W-1:0] SHORT_LEN = PC_W'(2);
    localparam logic [PC_W-1:0] LONG_LEN  = PC_W'(4);

    logic [PC_W-1:0] short_ext;
    logic [PC_W-1:0] long_ext;

    assign short_ext = {{(PC_W-SHORT_W){short_off[SHORT_W-1]}}, short_off};

    generate
        if (LONG_W < PC_W) begin : g_long_sext
            assign long_ext = {{(PC_W-LONG_W){long_off[LONG_W-1]}}, long_off};
        end else begin : g_long_trunc
            assign long_ext = long_off[PC_W-1:0];
        end
    endgenerate

    always_comb begin
        fall_pc = pc + (is_long ? LONG_LEN : SHORT_LEN);
        tgt_pc  = fall_pc + (is_long ? long_ext : short_ext);
    end
endmodule

// File: rtl/rbt_unit.sv
module rbt_unit
    import rbt_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [BYTE_W-1:0] ins_b0,
    input  logic [BYTE_W-1:0] ins_b1,
    input  logic [BYTE_W-1:0] ins_b2,
    input  logic [BYTE_W-1:0] ins_b3,
    input  logic              flag_z,
    output logic              out_valid,
    output logic [PC_W-1:0]   next_pc,
    output logic              taken,
    output logic              is_branch
);
    localparam int SHORT_W = BYTE_W;
    localparam int LONG_W  = 2 * BYTE_W;

    typedef struct packed {
        logic            valid;
        logic            branch;
        logic            taken;
        logic [PC_W-1:0] pc;
    } res_t;

    res_t st_d, st_q;

    br_kind_e        kind;
    logic            is_long;
    logic            cond_take;
    logic [PC_W-1:0] fall_pc;
    logic [PC_W-1:0] tgt_pc;

    rbt_decode u_dec (
        .b0      (ins_b0),
        .b1      (ins_b1),
        .kind    (kind),
        .is_long (is_long)
    );

    rbt_cond u_cond (
        .kind (kind),
        .zero (flag_z),
        .take (cond_take)
    );

    rbt_addr #(
        .PC_W    (PC_W),
        .SHORT_W (SHORT_W),
        .LONG_W  (LONG_W)
    ) u_addr (
        .pc        (pc_in),
        .is_long   (is_long),
        .short_off (ins_b1),
        .long_off  ({ins_b2, ins_b3}),
        .fall_pc   (fall_pc),
        .tgt_pc    (tgt_pc)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.branch = (kind != BK_NONE);
            st_d.taken  = cond_take;
            if (kind == BK_NONE) begin
                st_d.pc = pc_in;
            end else begin
                st_d.pc = cond_take ? tgt_pc : fall_pc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign next_pc   = st_q.pc;
    assign taken     = st_q.taken;
    assign is_branch = st_q.branch;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(next_pc) && $stable(taken) && $stable(is_branch))); // R9
    AST_SHORT_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ins_b0 == OPC_ALWAYS) |=> (taken && is_branch)); // R3
    AST_LONG_EQ_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ins_b0 == OPC_LONG_PREFIX && ins_b1 == OPC_IF_EQ && !flag_z)
        |=> (!taken && next_pc == $past(pc_in) + PC_W'(4))); // R6
    AST_SHORT_NE_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ins_b0 == OPC_IF_NE && flag_z)
        |=> (!taken && next_pc == $past(pc_in) + PC_W'(2))); // R5
    AST_TAKEN_IS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> is_branch); // R8
endmodule

// File: tb/rbt_unit_test.sv
`timescale 1ns/1ps
module rbt_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  ins_b0 = '0, ins_b1 = '0, ins_b2 = '0, ins_b3 = '0;
    logic        flag_z = 1'b0;
    logic        out_valid;
    logic [15:0] next_pc;
    logic        taken;
    logic        is_branch;

    int compared = 0;
    int mismatched = 0;

    logic        e_valid = 1'b0;
    logic [15:0] e_pc = '0;
    logic        e_taken = 1'b0;
    logic        e_br = 1'b0;

    always #4 clk = ~clk;

    rbt_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc_in(pc_in),
        .ins_b0(ins_b0), .ins_b1(ins_b1), .ins_b2(ins_b2), .ins_b3(ins_b3),
        .flag_z(flag_z), .out_valid(out_valid), .next_pc(next_pc),
        .taken(taken), .is_branch(is_branch)
    );

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Behavioural reference: integer arithmetic, reduced to 16 bits at the end
    task automatic model(input logic v, input int pc, input int b0, input int b1,
                         input int b2, input int b3, input logic z);
        int  op, len, off, kind;
        logic lng;
        e_valid = v;
        if (!v) return;
        lng = (b0 == 'h18);
        op  = lng ? b1 : b0;
        len = lng ? 4 : 2;
        off = lng ? ((b2 << 8) | b3) : ((b1 >= 128) ? b1 - 256 : b1);
        kind = (op == 'h20) ? 1 : (op == 'h27) ? 2 : (op == 'h26) ? 3 : 0;
        e_br = (kind != 0);
        e_taken = (kind == 1) || (kind == 2 && z) || (kind == 3 && !z);
        if (kind == 0) e_pc = 16'(pc);
        else if (e_taken) e_pc = 16'(pc + len + off);
        else e_pc = 16'(pc + len);
    endtask

    task automatic step(input string req, input logic v, input int pc, input int b0,
                        input int b1, input int b2, input int b3, input logic z);
        in_valid = v; pc_in = 16'(pc);
        ins_b0 = 8'(b0); ins_b1 = 8'(b1); ins_b2 = 8'(b2); ins_b3 = 8'(b3);
        flag_z = z;
        model(v, pc, b0, b1, b2, b3, z);
        @(posedge clk);
        @(negedge clk);
        chk({req, " out_valid (R2)"}, int'(out_valid), int'(e_valid));
        chk({req, " next_pc"}, int'(next_pc), int'(e_pc));
        chk({req, " taken"}, int'(taken), int'(e_taken));
        chk({req, " is_branch"}, int'(is_branch), int'(e_br));
    endtask

    initial begin
        #(8 * 150000);
        mismatched++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 next_pc", int'(next_pc), 0);
        chk("R1 taken", int'(taken), 0);
        chk("R1 is_branch", int'(is_branch), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", int'(next_pc), 0);

        step("R3 fwd",       1, 'h0800, 'h20, 'h35, 0, 0, 0);
        chk("R3 value 0837", int'(next_pc), 'h0837);
        step("R3 back",      1, 'h0800, 'h20, 'hC7, 0, 0, 1);
        chk("R3 value 07C9", int'(next_pc), 'h07C9);
        step("R3 0E",        1, 'h0820, 'h20, 'h0E, 0, 0, 0);
        chk("R3 value 0830", int'(next_pc), 'h0830);
        step("R4 eq z1",     1, 'h2000, 'h27, 'hF0, 0, 0, 1);
        step("R4 eq z0",     1, 'h2000, 'h27, 'hF0, 0, 0, 0);
        chk("R4 fallthru", int'(next_pc), 'h2002);
        step("R5 ne z0",     1, 'h3000, 'h26, 'h10, 0, 0, 0);
        step("R5 ne z1",     1, 'h3000, 'h26, 'h10, 0, 0, 1);
        step("R6 leq z1",    1, 'h1000, 'h18, 'h27, 'h02, 'h1A, 1);
        chk("R6 value 121E", int'(next_pc), 'h121E);
        step("R6 leq z0",    1, 'h1000, 'h18, 'h27, 'h02, 'h1A, 0);
        chk("R6 value 1004", int'(next_pc), 'h1004);
        step("R6 lbra back", 1, 'h4000, 'h18, 'h20, 'hFF, 'h00, 0);
        step("R6 lne",       1, 'h4000, 'h18, 'h26, 'h00, 'h40, 0);
        step("R7 short wrap",1, 'hFFFE, 'h20, 'h05, 0, 0, 0);
        chk("R7 value 0005", int'(next_pc), 'h0005);
        step("R7 long wrap", 1, 'hFFF0, 'h18, 'h20, 'h00, 'h20, 0);
        step("R7 low wrap",  1, 'h0000, 'h20, 'h80, 0, 0, 0);
        step("R8 unknown",   1, 'h5555, 'h86, 'h17, 0, 0, 1);
        step("R8 bad long",  1, 'h6666, 'h18, 'h06, 'h12, 'h34, 1);
        step("R9 idle",      0, 'h1234, 'h20, 'h10, 0, 0, 0);
        step("R9 idle2",     0, 'h0BAD, 'h18, 'h20, 1, 2, 1);

        for (int i = 0; i < 400; i++) begin
            int sel, b0, b1;
            logic v;
            sel = $urandom_range(0, 9);
            v = ($urandom_range(0, 4) != 0);
            case (sel)
                0: begin b0 = 'h20; b1 = $urandom_range(0, 255); end
                1: begin b0 = 'h27; b1 = $urandom_range(0, 255); end
                2: begin b0 = 'h26; b1 = $urandom_range(0, 255); end
                3: begin b0 = 'h18; b1 = 'h20; end
                4: begin b0 = 'h18; b1 = 'h27; end
                5: begin b0 = 'h18; b1 = 'h26; end
                6: begin b0 = 'h18; b1 = $urandom_range(0, 255); end
                default: begin b0 = $urandom_range(0, 255); b1 = $urandom_range(0, 255); end
            endcase
            step("R3 R4 R5 R6 R8 random", v, $urandom_range(0, 65535), b0, b1,
                 $urandom_range(0, 255), $urandom_range(0, 255), 1'($urandom_range(0, 1)));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule